// File: doc/BRIEF.md
# Exception Priority and Entry Controller

This block decides which of seven pending exception sources a 32-bit processor core takes next, and produces every side effect of taking it in a single registered step. The sources are external reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction and software interrupt. Each cycle it samples the request lines, the current program status word (PSR), an instruction-boundary flag and the address of the next instruction. One clock edge later it presents the winning exception's mode, its vector address for the program counter, the return address with a write strobe for the banked link register, the old PSR with a write strobe for the saved-status register, and the PSR the core should adopt.

The two interrupt sources are held back by the PSR mask bits and by the boundary flag. Aborts, undefined instruction and software interrupt are taken as soon as they are raised. The vector base, the address width and whether reset entry saves state are parameters.

Top module: `exc_entry_ctrl`

## Requirements
- R1: The vector address equals VECTOR_BASE plus a fixed offset: reset 0x00, undefined instruction 0x04, software interrupt 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R2: The entry mode is 5'b10011 (supervisor) for reset and software interrupt, 5'b11011 for undefined instruction, 5'b10111 for either abort, 5'b10010 for normal interrupt and 5'b10001 for fast interrupt.
- R3: When several qualified requests are present, the winner is chosen in this order, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt.
- R4: A normal-interrupt request is ignored while PSR bit 7 is 1. A fast-interrupt request is ignored while PSR bit 6 is 1. A lower-priority source then wins instead.
- R5: Interrupt requests are taken only when `insn_boundary` is 1. Aborts, undefined instruction and software interrupt are taken whatever its value.
- R6: On a non-reset entry, `link_we` and `spsr_we` are 1. `link_wdata` holds the sampled `next_pc` and `spsr_wdata` holds the sampled PSR.
- R7: `psr_next` keeps bits 31..8 and bit 5 of the old PSR. It sets bit 7 and puts the entry mode in bits 4..0. Bit 6 is set on fast-interrupt and reset entry and copied from the old PSR otherwise.
- R8: With SAVE_ON_RESET = 0 (the default), a reset entry raises neither `link_we` nor `spsr_we`.
- R9: Outputs change on the clock edge that samples the requests. In a cycle with no qualified request, `entry_take`, `link_we` and `spsr_we` are 0.
- R10: While `rst_n` is 0, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| req_reset | input | 1 | Processor reset exception request |
| req_dabort | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabort | input | 1 | Prefetch abort request |
| req_undef | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| insn_boundary | input | 1 | Current instruction has completed |
| cur_psr | input | 32 | Current program status word |
| next_pc | input | AW | Address of the next instruction |
| entry_take | output | 1 | An exception was taken this cycle |
| entry_mode | output | 5 | Mode entered |
| pc_vector | output | AW | Vector address to load into the PC |
| link_we | output | 1 | Banked link register write strobe |
| link_wdata | output | AW | Return address to store |
| spsr_we | output | 1 | Saved-status register write strobe |
| spsr_wdata | output | 32 | Old PSR to store |
| psr_next | output | 32 | PSR after entry |

## Verification
The bench goes after the priority chain by presenting nested sets of requests and stripping the current winner each time. A misordered chain would vector to the wrong address, for example letting a prefetch abort beat a normal interrupt. It checks mask and boundary gating: a design that ignored bit 7, bit 6 or the boundary flag would take an interrupt it should skip, while one that gated aborts on the boundary would miss a data abort mid-instruction. It also checks that bit 6 is set only for fast interrupt and reset, that flags and the T bit survive entry, that reset entry does not save state, and that strobes fall in the cycle after a request goes away.

// File: rtl/exc_pkg.sv
package exc_pkg;

   localparam int NSRC   = 7;
   localparam int IDX_W  = 3;
   localparam int PSR_W  = 32;
   localparam int MODE_W = 5;
   localparam int BIT_IM = 7;
   localparam int BIT_FM = 6;
   localparam int BIT_T  = 5;

   // Source index doubles as priority rank: lower index wins.
   localparam int SRC_RESET = 0;
   localparam int SRC_DABT  = 1;
   localparam int SRC_FIQ   = 2;
   localparam int SRC_IRQ   = 3;
   localparam int SRC_PABT  = 4;
   localparam int SRC_UNDEF = 5;
   localparam int SRC_SWI   = 6;

   typedef enum logic [MODE_W-1:0] {
      MODE_USR = 5'b10000,
      MODE_FIQ = 5'b10001,
      MODE_IRQ = 5'b10010,
      MODE_SVC = 5'b10011,
      MODE_ABT = 5'b10111,
      MODE_UND = 5'b11011
   } cpu_mode_e;

   function automatic logic [4:0] vec_offset(input logic [IDX_W-1:0] idx);
      case (idx)
         3'(SRC_RESET): return 5'h00;
         3'(SRC_DABT):  return 5'h10;
         3'(SRC_FIQ):   return 5'h1C;
         3'(SRC_IRQ):   return 5'h18;
         3'(SRC_PABT):  return 5'h0C;
         3'(SRC_UNDEF): return 5'h04;
         default:       return 5'h08;
      endcase
   endfunction

   function automatic cpu_mode_e entry_mode_of(input logic [IDX_W-1:0] idx);
      case (idx)
         3'(SRC_RESET): return MODE_SVC;
         3'(SRC_DABT):  return MODE_ABT;
         3'(SRC_FIQ):   return MODE_FIQ;
         3'(SRC_IRQ):   return MODE_IRQ;
         3'(SRC_PABT):  return MODE_ABT;
         3'(SRC_UNDEF): return MODE_UND;
         default:       return MODE_SVC;
      endcase
   endfunction

endpackage

// File: rtl/exc_qualify.sv
module exc_qualify
   import exc_pkg::*;
(
   input  logic [NSRC-1:0] raw_req,
   input  logic            irq_masked,
   input  logic            fiq_masked,
   input  logic            boundary,
   output logic [NSRC-1:0] qual_req
);

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (i == SRC_IRQ) begin : g_irq
         assign qual_req[i] = raw_req[i] & boundary & ~irq_masked;
      end else if (i == SRC_FIQ) begin : g_fiq
         assign qual_req[i] = raw_req[i] & boundary & ~fiq_masked;
      end else begin : g_sync
         assign qual_req[i] = raw_req[i];
      end
   end

endmodule

// File: rtl/exc_prio.sv
module exc_prio
   import exc_pkg::*;
(
   input  logic [NSRC-1:0]  qual_req,
   output logic             any_req,
   output logic [IDX_W-1:0] win_idx
);

   always_comb begin
      win_idx = '0;
      for (int i = NSRC - 1; i >= 0; i--) begin
         if (qual_req[i]) win_idx = IDX_W'(i);
      end
   end

   assign any_req = |qual_req;

endmodule

// File: rtl/exc_vecmap.sv
module exc_vecmap
   import exc_pkg::*;
#(
   parameter int          AW          = 32,
   parameter logic [AW-1:0] VECTOR_BASE = '0
) (
   input  logic [IDX_W-1:0] win_idx,
   output logic [AW-1:0]    vec_addr,
   output cpu_mode_e        mode,
   output logic             set_fmask
);

   assign vec_addr  = VECTOR_BASE | {{(AW-5){1'b0}}, vec_offset(win_idx)};
   assign mode      = entry_mode_of(win_idx);
   assign set_fmask = (win_idx == IDX_W'(SRC_FIQ)) || (win_idx == IDX_W'(SRC_RESET));

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
   import exc_pkg::*;
#(
   parameter int            AW            = 32,
   parameter logic [AW-1:0] VECTOR_BASE   = '0,
   parameter bit            SAVE_ON_RESET = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_reset,
   input  logic                req_dabort,
   input  logic                req_fiq,
   input  logic                req_irq,
   input  logic                req_pabort,
   input  logic                req_undef,
   input  logic                req_swi,
   input  logic                insn_boundary,
   input  logic [31:0]         cur_psr,
   input  logic [AW-1:0]       next_pc,
   output logic                entry_take,
   output logic [4:0]          entry_mode,
   output logic [AW-1:0]       pc_vector,
   output logic                link_we,
   output logic [AW-1:0]       link_wdata,
   output logic                spsr_we,
   output logic [31:0]         spsr_wdata,
   output logic [31:0]         psr_next
);

   if (AW < 8) begin : g_bad_aw
      $error("exc_entry_ctrl: AW must be at least 8");
   end
   if (VECTOR_BASE[4:0] != 5'd0) begin : g_bad_base
      $error("exc_entry_ctrl: VECTOR_BASE must be 32-byte aligned");
   end

   logic [NSRC-1:0]  raw_req, qual_req;
   logic             any_req, set_fmask, save_ok;
   logic [IDX_W-1:0] win_idx;
   logic [AW-1:0]    vec_addr;
   cpu_mode_e        win_mode;
   logic [31:0]      psr_after;

   assign raw_req = {req_swi, req_undef, req_pabort, req_irq,
                     req_fiq, req_dabort, req_reset};

   exc_qualify u_qual (
      .raw_req    (raw_req),
      .irq_masked (cur_psr[BIT_IM]),
      .fiq_masked (cur_psr[BIT_FM]),
      .boundary   (insn_boundary),
      .qual_req   (qual_req)
   );

   exc_prio u_prio (
      .qual_req (qual_req),
      .any_req  (any_req),
      .win_idx  (win_idx)
   );

   exc_vecmap #(.AW(AW), .VECTOR_BASE(VECTOR_BASE)) u_vmap (
      .win_idx   (win_idx),
      .vec_addr  (vec_addr),
      .mode      (win_mode),
      .set_fmask (set_fmask)
   );

   if (SAVE_ON_RESET) begin : g_save_all
      assign save_ok = 1'b1;
   end else begin : g_skip_reset_save
      assign save_ok = (win_idx != IDX_W'(SRC_RESET));
   end

   assign psr_after = {cur_psr[31:8], 1'b1, cur_psr[BIT_FM] | set_fmask,
                       cur_psr[BIT_T], win_mode};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         entry_take <= 1'b0;
         entry_mode <= '0;
         pc_vector  <= '0;
         link_we    <= 1'b0;
         link_wdata <= '0;
         spsr_we    <= 1'b0;
         spsr_wdata <= '0;
         psr_next   <= '0;
      end else begin
         entry_take <= any_req;
         link_we    <= any_req & save_ok;
         spsr_we    <= any_req & save_ok;
         if (any_req) begin
            entry_mode <= win_mode;
            pc_vector  <= vec_addr;
            link_wdata <= next_pc;
            spsr_wdata <= cur_psr;
            psr_next   <= psr_after;
         end
      end
   end

endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
   import exc_pkg::*;
#(
   parameter int            AW            = 32,
   parameter logic [AW-1:0] VECTOR_BASE   = '0,
   parameter bit            SAVE_ON_RESET = 1'b0
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_reset,
   input logic          req_dabort,
   input logic          req_fiq,
   input logic          req_irq,
   input logic          req_pabort,
   input logic          req_undef,
   input logic          req_swi,
   input logic          insn_boundary,
   input logic [31:0]   cur_psr,
   input logic [AW-1:0] next_pc,
   input logic          entry_take,
   input logic [4:0]    entry_mode,
   input logic [AW-1:0] pc_vector,
   input logic          link_we,
   input logic [AW-1:0] link_wdata,
   input logic          spsr_we,
   input logic [31:0]   spsr_wdata,
   input logic [31:0]   psr_next
);

   logic only_irq;
   assign only_irq = req_irq & ~req_reset & ~req_dabort & ~req_fiq &
                     ~req_pabort & ~req_undef & ~req_swi;

   a_r3_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
      req_reset |=> entry_take && pc_vector == VECTOR_BASE && entry_mode == MODE_SVC);

   a_r4_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
      (only_irq && cur_psr[BIT_IM]) |=> !entry_take);

   a_r5_irq_waits_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      (only_irq && !insn_boundary) |=> !entry_take);

   a_r5_dabort_immediate: assert property (@(posedge clk) disable iff (!rst_n)
      (req_dabort && !req_reset) |=> entry_take && entry_mode == MODE_ABT);

   a_r6_link_value: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_take && link_we) |-> link_wdata == $past(next_pc));

   a_r6_spsr_value: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_take && spsr_we) |-> spsr_wdata == $past(cur_psr));

   a_r7_imask_set: assert property (@(posedge clk) disable iff (!rst_n)
      entry_take |-> psr_next[BIT_IM] && psr_next[4:0] == entry_mode);

   a_r9_idle_strobes: assert property (@(posedge clk) disable iff (!rst_n)
      !entry_take |-> !link_we && !spsr_we);

   if (!SAVE_ON_RESET) begin : g_r8
      a_r8_reset_no_save: assert property (@(posedge clk) disable iff (!rst_n)
         req_reset |=> !link_we && !spsr_we);
   end

endmodule

bind exc_entry_ctrl exc_entry_chk #(
   .AW(AW), .VECTOR_BASE(VECTOR_BASE), .SAVE_ON_RESET(SAVE_ON_RESET)
) u_exc_entry_chk (.*);

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [6:0]  req = '0;   // {swi, undef, pabt, irq, fiq, dabt, reset}
   logic        bnd = 1'b1;
   logic [31:0] psr = 32'h0000_0010;
   logic [31:0] npc = '0;
   logic        entry_take, link_we, spsr_we;
   logic [4:0]  entry_mode;
   logic [31:0] pc_vector, link_wdata, spsr_wdata, psr_next;
   int checks = 0, fails = 0;
   bit done = 1'b0;

   localparam logic [6:0] Q_RST = 7'h01, Q_DAB = 7'h02, Q_FIQ = 7'h04, Q_IRQ = 7'h08,
                          Q_PAB = 7'h10, Q_UND = 7'h20, Q_SWI = 7'h40;

   always #4 clk = ~clk;

   exc_entry_ctrl i_exc_entry_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_reset(req[0]), .req_dabort(req[1]), .req_fiq(req[2]), .req_irq(req[3]),
      .req_pabort(req[4]), .req_undef(req[5]), .req_swi(req[6]),
      .insn_boundary(bnd), .cur_psr(psr), .next_pc(npc),
      .entry_take(entry_take), .entry_mode(entry_mode), .pc_vector(pc_vector),
      .link_we(link_we), .link_wdata(link_wdata), .spsr_we(spsr_we),
      .spsr_wdata(spsr_wdata), .psr_next(psr_next)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [6:0] r, input logic [31:0] p, input logic b,
                        input logic [31:0] pc);
      @(negedge clk);
      req = r; psr = p; bnd = b; npc = pc;
      @(posedge clk); #1;
   endtask

   // One entry with full expected-result check.
   task automatic entry(input string tag, input logic [6:0] r, input logic [31:0] p,
                        input logic b, input logic [31:0] vec, input logic [4:0] mode,
                        input logic save, input logic fset);
      logic [31:0] exp_psr;
      drive(r, p, b, 32'h0000_4A10);
      exp_psr = {p[31:8], 1'b1, p[6] | fset, p[5], mode};
      chk({tag, " R9 take"}, 32'(entry_take), 32'd1);
      chk({tag, " R1 vector"}, pc_vector, vec);
      chk({tag, " R2 mode"}, 32'(entry_mode), 32'(mode));
      chk({tag, " R6 R8 link_we"}, 32'(link_we), 32'(save));
      chk({tag, " R6 R8 spsr_we"}, 32'(spsr_we), 32'(save));
      if (save) begin
         chk({tag, " R6 link data"}, link_wdata, 32'h0000_4A10);
         chk({tag, " R6 spsr data"}, spsr_wdata, p);
      end
      chk({tag, " R7 psr_next"}, psr_next, exp_psr);
   endtask

   task automatic none(input string tag, input logic [6:0] r, input logic [31:0] p,
                       input logic b);
      drive(r, p, b, 32'h0000_0100);
      chk({tag, " take"}, 32'(entry_take), 32'd0);
      chk({tag, " R9 strobes"}, 32'({link_we, spsr_we}), 32'd0);
   endtask

   task automatic t_reset_state;
      chk("R10 reset outputs", {31'd0, entry_take} | pc_vector | psr_next | link_wdata
          | spsr_wdata | {27'd0, entry_mode} | {30'd0, link_we, spsr_we}, 32'd0);
   endtask

   task automatic t_each_source;
      logic [31:0] p = 32'hA000_0030;
      entry("single reset", Q_RST, p, 1, 32'h00, 5'b10011, 0, 1);
      entry("single undef", Q_UND, p, 1, 32'h04, 5'b11011, 1, 0);
      entry("single swi",   Q_SWI, p, 1, 32'h08, 5'b10011, 1, 0);
      entry("single pabt",  Q_PAB, p, 1, 32'h0C, 5'b10111, 1, 0);
      entry("single dabt",  Q_DAB, p, 1, 32'h10, 5'b10111, 1, 0);
      entry("single irq",   Q_IRQ, p, 1, 32'h18, 5'b10010, 1, 0);
      entry("single fiq",   Q_FIQ, p, 1, 32'h1C, 5'b10001, 1, 1);
   endtask

   task automatic t_priority;
      logic [31:0] p = 32'h5000_0010;
      entry("R3 all->reset", 7'h7F, p, 1, 32'h00, 5'b10011, 0, 1);
      entry("R3 ->dabt",     7'h7E, p, 1, 32'h10, 5'b10111, 1, 0);
      entry("R3 ->fiq",      7'h7C, p, 1, 32'h1C, 5'b10001, 1, 1);
      entry("R3 ->irq",      7'h78, p, 1, 32'h18, 5'b10010, 1, 0);
      entry("R3 ->pabt",     7'h70, p, 1, 32'h0C, 5'b10111, 1, 0);
      entry("R3 ->undef",    7'h60, p, 1, 32'h04, 5'b11011, 1, 0);
   endtask

   task automatic t_masks;
      none("R4 irq masked", Q_IRQ, 32'h0000_0090, 1);
      none("R4 fiq masked", Q_FIQ, 32'h0000_0050, 1);
      entry("R4 irq masked pabt wins", Q_IRQ | Q_PAB, 32'h0000_0090, 1,
            32'h0C, 5'b10111, 1, 0);
      entry("R4 fiq masked irq wins", Q_FIQ | Q_IRQ, 32'h0000_0050, 1,
            32'h18, 5'b10010, 1, 0);
      entry("R7 fiq bit kept on irq", Q_IRQ, 32'hF000_0053, 1, 32'h18, 5'b10010, 1, 0);
   endtask

   task automatic t_boundary;
      none("R5 irq mid-insn", Q_IRQ, 32'h0000_0010, 0);
      none("R5 fiq mid-insn", Q_FIQ, 32'h0000_0010, 0);
      entry("R5 dabt mid-insn", Q_DAB | Q_FIQ, 32'h0000_0010, 0, 32'h10, 5'b10111, 1, 0);
      entry("R5 undef mid-insn", Q_UND, 32'h0000_0010, 0, 32'h04, 5'b11011, 1, 0);
   endtask

   task automatic t_idle_and_reset;
      entry("R9 entry before idle", Q_SWI, 32'h0000_0010, 1, 32'h08, 5'b10011, 1, 0);
      none("R9 idle after entry", 7'h00, 32'h0000_0010, 1);
      entry("R10 entry before reset", Q_DAB, 32'h0000_0010, 1, 32'h10, 5'b10111, 1, 0);
      @(negedge clk);
      req = '0;
      rst_n = 1'b0;
      #1;
      t_reset_state();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      t_reset_state();
      @(negedge clk);
      rst_n = 1'b1;
      t_each_source();
      t_priority();
      t_masks();
      t_boundary();
      t_idle_and_reset();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

endmodule